// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 9-bit first-in first-out buffer that connects two unrelated clock domains. A producer writes words on the write clock and a consumer reads them on the read clock. The storage depth is a power of two between 256 and 8192 words, chosen by a parameter. The write and read pointers are one bit wider than the address. Each pointer crosses to the other domain as Gray code through a two-flop synchroniser.

There are four active-low status outputs. Full and almost-full are registered on the write clock. Empty and almost-empty are registered on the read clock. Each flag comes from an exact word count that is computed in its own domain. The two thresholds are held in run-time offset registers: m sets almost-full and n sets almost-empty. Each register is loaded by a one-cycle strobe in its own domain, and both return to 7 on reset. A flag asserts in the same cycle as the local operation that causes it. It deasserts only after the other domain's pointer has passed through the synchroniser. Writes are refused while full, and reads are refused while empty.

Top module: `fifo9_dcflags`

## Requirements
- R1: Words are read out in the order in which they were accepted, with all 9 bits unchanged. Read data appears on `rd_data` after the read-clock rising edge that accepts the read.
- R2: `full_n` goes low at the write-clock edge that accepts the DEPTH-th stored word. With no reads after reset, this is the DEPTH-th write.
- R3: While `full_n` is low, `wr_en` is ignored. Neither the write pointer nor any stored word changes.
- R4: `empty_n` is low while the FIFO holds 0 words, and it goes low at the read-clock edge that removes the last word. While it is low, `rd_en` is ignored and the read pointer does not move.
- R5: `afull_n` is low exactly when the word count is at least DEPTH-m. With no reads, it falls at the write that brings the count to DEPTH-m.
- R6: `aempty_n` is low exactly when the word count is at most n, and high once the count is n+1 or more.
- R7: After reset, m = n = 7. Almost-full then starts at DEPTH-7 words, and almost-empty ends at 7 words.
- R8: A one-cycle `wr_off_ld` loads m from `wr_off_val`, and a one-cycle `rd_off_ld` loads n from `rd_off_val`. Each value is unsigned and AW = log2(DEPTH) bits wide. It is clamped so that 0 becomes 1 and any value above DEPTH-2 becomes DEPTH-2.
- R9: When `arst_n` is low, both pointers are zero, `empty_n` and `aempty_n` are low, `full_n` and `afull_n` are high, and both offsets are 7.
- R10: The pointers cross domains in Gray code, and each step changes one bit. A flag whose cause lies in the other domain reaches its new value within four cycles of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to store |
| wr_off_ld | input | 1 | Load strobe for the almost-full offset m |
| wr_off_val | input | AW | New value for m |
| rd_en | input | 1 | Read request |
| rd_off_ld | input | 1 | Load strobe for the almost-empty offset n |
| rd_off_val | input | AW | New value for n |
| rd_data | output | 9 | Word read out |
| full_n | output | 1 | Low when DEPTH words are held |
| afull_n | output | 1 | Low when count >= DEPTH-m |
| empty_n | output | 1 | Low when no words are held |
| aempty_n | output | 1 | Low when count <= n |

## Verification
A wrong pointer or a corrupted stored word shows up at the ports on the first read that reaches it: `rd_data` no longer matches the word the bench expects in order. A pointer that moves on a refused write shows up immediately, because the count wraps and `empty_n` or `full_n` go wrong. A misplaced threshold shows up at the single write or read that crosses it, because the flags are checked after every operation during back-to-back fills and drains. A slow or broken synchroniser shows up as a flag that is still stale after the settling window.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

    localparam int WORD_W  = 9;
    localparam int DEF_OFF = 7;
    localparam int PTR_CAP = 14;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [PTR_CAP-1:0] ptr_cap_t;

    // bound_n: full (write side) or empty (read side); near_n: the programmable one
    typedef struct packed {
        logic bound_n;
        logic near_n;
    } flag_pair_t;

    function automatic ptr_cap_t to_gray(ptr_cap_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_cap_t from_gray(ptr_cap_t g);
        ptr_cap_t b;
        b[PTR_CAP-1] = g[PTR_CAP-1];
        for (int i = PTR_CAP-2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic ptr_cap_t clamp_offset(ptr_cap_t v, ptr_cap_t hi);
        if (v == '0) return ptr_cap_t'(1);
        if (v > hi)  return hi;
        return v;
    endfunction

endpackage

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fifo9_ram.sv
module fifo9_ram
    import fifo9_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= cells[raddr];
    end
endmodule

// File: rtl/fifo9_wr_ctl.sv
module fifo9_wr_ctl
    import fifo9_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          push,
    input  logic          off_ld,
    input  logic [AW-1:0] off_val,
    input  logic [PW-1:0] peer_gray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] ptr_bin,
    output logic [PW-1:0] ptr_gray,
    output flag_pair_t    flags
);
    localparam logic [PW-1:0] CAP    = PW'(DEPTH);
    localparam ptr_cap_t      OFF_HI = ptr_cap_t'(DEPTH - 2);

    logic          accept;
    logic [PW-1:0] bin_nx;
    logic [PW-1:0] peer_bin;
    logic [PW-1:0] level_nx;
    logic [PW-1:0] thresh;
    logic [PW-1:0] m_off;
    flag_pair_t    flags_nx;

    always_comb begin
        accept            = push & flags.bound_n;
        bin_nx            = ptr_bin + PW'(accept);
        peer_bin          = PW'(from_gray(ptr_cap_t'(peer_gray_s)));
        level_nx          = bin_nx - peer_bin;
        thresh            = CAP - m_off;
        flags_nx.bound_n  = (level_nx != CAP);
        flags_nx.near_n   = (level_nx < thresh);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
            flags    <= '{bound_n: 1'b1, near_n: 1'b1};
            m_off    <= PW'(DEF_OFF);
        end else begin
            ptr_bin  <= bin_nx;
            ptr_gray <= PW'(to_gray(ptr_cap_t'(bin_nx)));
            flags    <= flags_nx;
            if (off_ld) m_off <= PW'(clamp_offset(ptr_cap_t'(off_val), OFF_HI));
        end
    end

    assign mem_we   = accept;
    assign mem_addr = ptr_bin[AW-1:0];
endmodule

// File: rtl/fifo9_rd_ctl.sv
module fifo9_rd_ctl
    import fifo9_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          pop,
    input  logic          off_ld,
    input  logic [AW-1:0] off_val,
    input  logic [PW-1:0] peer_gray_s,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] ptr_bin,
    output logic [PW-1:0] ptr_gray,
    output flag_pair_t    flags
);
    localparam ptr_cap_t OFF_HI = ptr_cap_t'(DEPTH - 2);

    logic          accept;
    logic [PW-1:0] bin_nx;
    logic [PW-1:0] peer_bin;
    logic [PW-1:0] level_nx;
    logic [PW-1:0] n_off;
    flag_pair_t    flags_nx;

    always_comb begin
        accept            = pop & flags.bound_n;
        bin_nx            = ptr_bin + PW'(accept);
        peer_bin          = PW'(from_gray(ptr_cap_t'(peer_gray_s)));
        level_nx          = peer_bin - bin_nx;
        flags_nx.bound_n  = (level_nx != '0);
        flags_nx.near_n   = (level_nx > n_off);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
            flags    <= '{bound_n: 1'b0, near_n: 1'b0};
            n_off    <= PW'(DEF_OFF);
        end else begin
            ptr_bin  <= bin_nx;
            ptr_gray <= PW'(to_gray(ptr_cap_t'(bin_nx)));
            flags    <= flags_nx;
            if (off_ld) n_off <= PW'(clamp_offset(ptr_cap_t'(off_val), OFF_HI));
        end
    end

    assign mem_re   = accept;
    assign mem_addr = ptr_bin[AW-1:0];
endmodule

// File: rtl/fifo9_dcflags.sv
module fifo9_dcflags
    import fifo9_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          arst_n,
    input  logic          wr_en,
    input  logic [8:0]    wr_data,
    input  logic          wr_off_ld,
    input  logic [AW-1:0] wr_off_val,
    input  logic          rd_en,
    input  logic          rd_off_ld,
    input  logic [AW-1:0] rd_off_val,
    output logic [8:0]    rd_data,
    output logic          full_n,
    output logic          afull_n,
    output logic          empty_n,
    output logic          aempty_n
);
    if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 256 || DEPTH > 8192) begin : g_bad_depth
        $error("fifo9_dcflags: DEPTH must be a power of two in 256..8192");
    end

    logic          mem_we, mem_re;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [PW-1:0] wr_ptr_bin, wr_ptr_gray, rd_ptr_bin, rd_ptr_gray;
    logic [PW-1:0] wr_gray_in_rd, rd_gray_in_wr;
    flag_pair_t    wflags, rflags;
    word_t         rdata_w;

    fifo9_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .arst_n(arst_n), .push(wr_en),
        .off_ld(wr_off_ld), .off_val(wr_off_val), .peer_gray_s(rd_gray_in_wr),
        .mem_we(mem_we), .mem_addr(mem_waddr),
        .ptr_bin(wr_ptr_bin), .ptr_gray(wr_ptr_gray), .flags(wflags)
    );

    fifo9_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .arst_n(arst_n), .pop(rd_en),
        .off_ld(rd_off_ld), .off_val(rd_off_val), .peer_gray_s(wr_gray_in_rd),
        .mem_re(mem_re), .mem_addr(mem_raddr),
        .ptr_bin(rd_ptr_bin), .ptr_gray(rd_ptr_gray), .flags(rflags)
    );

    fifo9_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .arst_n(arst_n), .d(wr_ptr_gray), .q(wr_gray_in_rd)
    );

    fifo9_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .arst_n(arst_n), .d(rd_ptr_gray), .q(rd_gray_in_wr)
    );

    fifo9_ram #(.DEPTH(DEPTH)) u_ram (
        .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(word_t'(wr_data)),
        .rclk(rd_clk), .re(mem_re), .raddr(mem_raddr), .rdata(rdata_w)
    );

    assign rd_data  = rdata_w;
    assign full_n   = wflags.bound_n;
    assign afull_n  = wflags.near_n;
    assign empty_n  = rflags.bound_n;
    assign aempty_n = rflags.near_n;
endmodule

// File: rtl/fifo9_dcflags_chk.sv
module fifo9_dcflags_chk #(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          arst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [PW-1:0] wr_ptr_bin,
    input logic [PW-1:0] rd_ptr_bin,
    input logic [PW-1:0] wr_ptr_gray,
    input logic [PW-1:0] rd_ptr_gray
);
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!arst_n)
        (!full_n && wr_en) |=> $stable(wr_ptr_bin));

    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!arst_n)
        (!empty_n && rd_en) |=> $stable(rd_ptr_bin));

    // R5 together with R2: a full FIFO is always also almost full
    a_r5_full_in_afull: assert property (@(posedge wr_clk) disable iff (!arst_n)
        !full_n |-> !afull_n);

    // R6 together with R4: an empty FIFO is always also almost empty
    a_r6_empty_in_aempty: assert property (@(posedge rd_clk) disable iff (!arst_n)
        !empty_n |-> !aempty_n);

    a_r10_wgray_step: assert property (@(posedge wr_clk) disable iff (!arst_n)
        $countones(wr_ptr_gray ^ $past(wr_ptr_gray)) <= 1);

    a_r10_rgray_step: assert property (@(posedge rd_clk) disable iff (!arst_n)
        $countones(rd_ptr_gray ^ $past(rd_ptr_gray)) <= 1);
endmodule

bind fifo9_dcflags fifo9_dcflags_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n),
    .wr_en(wr_en), .rd_en(rd_en),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
    .wr_ptr_bin(wr_ptr_bin), .rd_ptr_bin(rd_ptr_bin),
    .wr_ptr_gray(wr_ptr_gray), .rd_ptr_gray(rd_ptr_gray)
);

// File: tb/tb_fifo9_dcflags.sv
`timescale 1ns/1ps
module tb_fifo9_dcflags;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic          wr_clk = 0, rd_clk = 0, arst_n = 0;
    logic          wr_en = 0, rd_en = 0, wr_off_ld = 0, rd_off_ld = 0;
    logic [8:0]    wr_data = '0;
    logic [AW-1:0] wr_off_val = '0, rd_off_val = '0;
    logic [8:0]    rd_data;
    logic          full_n, afull_n, empty_n, aempty_n;

    fifo9_dcflags #(.DEPTH(DEPTH)) dut (.*);

    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.3;
        forever #2.5 rd_clk = ~rd_clk;
    end

    int     n_run = 0, n_fail = 0;
    bit     finished = 0;
    logic [8:0] q[$];
    int     mdl_m = 7, mdl_n = 7;

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_wr(string tag);
        int c = q.size();
        chk({tag, " full_n"},  full_n,  (c == DEPTH) ? 0 : 1);
        chk({tag, " afull_n"}, afull_n, (c >= DEPTH - mdl_m) ? 0 : 1);
    endtask

    task automatic check_rd(string tag);
        int c = q.size();
        chk({tag, " empty_n"},  empty_n,  (c == 0) ? 0 : 1);
        chk({tag, " aempty_n"}, aempty_n, (c <= mdl_n) ? 0 : 1);
    endtask

    task automatic settle();
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic wr_word(logic [8:0] d);
        @(negedge wr_clk); wr_en = 1; wr_data = d;
        @(negedge wr_clk); wr_en = 0;
        if (q.size() < DEPTH) q.push_back(d);
    endtask

    task automatic rd_word(string tag);
        logic [8:0] e;
        @(negedge rd_clk); rd_en = 1;
        @(negedge rd_clk); rd_en = 0;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk({tag, " data"}, rd_data, e);
        end
    endtask

    function automatic int clampv(int v);
        if (v == 0) return 1;
        if (v > DEPTH - 2) return DEPTH - 2;
        return v;
    endfunction

    task automatic load_offsets(int m, int n);
        @(negedge wr_clk); wr_off_ld = 1; wr_off_val = AW'(m);
        @(negedge wr_clk); wr_off_ld = 0;
        @(negedge rd_clk); rd_off_ld = 1; rd_off_val = AW'(n);
        @(negedge rd_clk); rd_off_ld = 0;
        mdl_m = clampv(m); mdl_n = clampv(n);
    endtask

    task automatic do_reset();
        @(negedge wr_clk); arst_n = 0;
        q.delete(); mdl_m = 7; mdl_n = 7;
        repeat (3) @(negedge wr_clk);
        check_wr("R9 reset"); check_rd("R9 reset");
        arst_n = 1;
        settle();
    endtask

    // fill back-to-back, then drain back-to-back, checking flags at every step
    task automatic fill_drain(string tag, int seed_mul);
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(9'((i * seed_mul + 5) % 512));
            check_wr({tag, " fill R2 R5"});
        end
        wr_word(9'h0FF);
        check_wr({tag, " write-when-full R3"});
        settle();
        check_rd({tag, " full settled R10"});
        for (int i = 0; i < DEPTH; i++) begin
            rd_word({tag, " order R1 R3"});
            check_rd({tag, " drain R4 R6"});
        end
        settle();
        check_wr({tag, " drained R10"});
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge wr_clk);
        check_wr("R9 at reset"); check_rd("R9 at reset");
        arst_n = 1;
        settle();

        // R4: read while empty must not move the read pointer
        rd_word("R4 empty read");
        chk("R4 empty read ignored", empty_n, 0);
        wr_word(9'h1A5);
        settle();
        check_rd("R4 one word");
        rd_word("R4 after ignored read R1");
        check_rd("R4 back to empty");

        // R7: defaults m = n = 7
        fill_drain("R7 default", 37);

        // R8: loaded offsets
        load_offsets(20, 30);
        for (int i = 0; i < 33; i++) begin
            wr_word(9'(i + 100));
            settle();
            check_rd("R8 n=30 R6");
            check_wr("R8 m=20 R5");
        end
        while (q.size() < DEPTH) begin
            wr_word(9'($urandom_range(0, 511)));
            check_wr("R8 m=20 fill R5");
        end
        settle();
        while (q.size() > 0) begin
            rd_word("R8 drain R1");
            check_rd("R8 n=30 drain R6");
        end
        settle();

        // R8 clamping: 0 -> 1, 255 -> DEPTH-2
        load_offsets(0, DEPTH - 1);
        fill_drain("R8 clamp", 11);

        // R9: reset mid-run restores pointers and offsets (R7)
        load_offsets(50, 50);
        for (int i = 0; i < 10; i++) wr_word(9'(i));
        do_reset();
        for (int i = 0; i < 8; i++) begin
            wr_word(9'(300 + i));
            settle();
            check_rd("R7 default n after reset");
            check_wr("R7 default m after reset");
        end
        while (q.size() > 0) rd_word("R9 post-reset order R1");
        settle();
        check_rd("R9 post-reset empty");

        // R1/R10: random bursts
        for (int r = 0; r < 60; r++) begin
            int nw = $urandom_range(0, (DEPTH - q.size() < 40) ? DEPTH - q.size() : 40);
            int nr;
            for (int i = 0; i < nw; i++) wr_word(9'($urandom_range(0, 511)));
            settle();
            check_rd("R10 after writes"); check_wr("R10 after writes");
            nr = $urandom_range(0, (q.size() < 40) ? q.size() : 40);
            for (int i = 0; i < nr; i++) rd_word("R1 random order");
            settle();
            check_rd("R10 after reads"); check_wr("R10 after reads");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #750000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule